// File: doc/BRIEF.md
# Bus READY and Reset Generator

This block produces the active-low bus READY that ends a processor bus cycle, and a synchronized active-high system reset. READY can come from either of two qualified sources. The synchronous pair is sampled directly. The asynchronous pair first crosses a falling-edge synchronizer. Each source is used only when its select input is also low, which an address decoder normally provides. The READY pin is modelled as an open-drain driver, so the block outputs a drive-low enable. When that enable is low, an external pull-up raises the line.

All state changes on the falling edge of the system clock. Candidate ready requests are examined only while the half-rate peripheral clock is high. Once the block drives READY, it keeps driving for a minimum hold time. After that, it stops driving when a new bus cycle's status is seen, or when the sampled request disappears. The reset request is synchronized to the same edge. While the synchronized reset is high, READY is forced active one clock later.

Top module: `bus_ready_gen`

## Requirements
- R1: The reset output goes high two falling edges after the reset request is first sampled low, and it goes low two falling edges after the request is first sampled high.
- R2: On the falling edge after any edge where the reset output is high, the READY drive enable is 1, whatever the status and ready inputs are.
- R3: On a falling edge where the peripheral clock is high, both status inputs are high, and the synchronous ready and its select are both low, the READY drive enable becomes 1.
- R4: The synchronous ready pair has no effect on a falling edge where the peripheral clock is low. It also has no effect when either status input is low.
- R5: The asynchronous ready and its select pass through a two-stage falling-edge synchronizer. A low pair applied before edge k can assert READY no earlier than edge k+2. That edge must also have the peripheral clock high. The release of the pair is delayed by the same amount.
- R6: When the synchronized asynchronous ready and select are both low, READY is asserted regardless of the synchronous pair. An asynchronous select alone, with the ready input high, never asserts READY.
- R7: Once the drive enable rises, it stays at 1 for at least two falling edges (MIN_HOLD), even if a status input goes low within that window.
- R8: After the hold window, a falling edge that sees either status input low sets the drive enable to 0, which releases the line to the pull-up.
- R9: After the hold window, on a peripheral-clock-high edge with both status inputs high, the drive enable stays at 1 while a qualified source is still active. It drops to 0 when no qualified source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; all state changes on its falling edge |
| periph_clk | input | 1 | Half-rate peripheral clock; ready sampling happens only while it is high |
| stat1_n | input | 1 | Bus status bit 1, active low |
| stat0_n | input | 1 | Bus status bit 0, active low |
| sync_rdy_n | input | 1 | Synchronous ready request, active low |
| sync_sel_n | input | 1 | Qualifier for the synchronous request, active low |
| async_rdy_n | input | 1 | Asynchronous ready request, active low |
| async_sel_n | input | 1 | Qualifier for the asynchronous request, active low |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| ready_pull_o | output | 1 | 1 = drive the READY line low; 0 = leave it to the pull-up |
| sys_reset_o | output | 1 | Synchronized system reset, active high |

## Verification
The bench builds the block with its default parameters: a hold of two clocks, a two-stage asynchronous synchronizer and a two-stage reset synchronizer. These small values keep each interaction within a few clocks of a short vector table. That makes it possible to check the exact edge where the asynchronous path takes effect and releases. It also shows the hold window overriding a bus-cycle start, and the forced READY following the reset output by one edge on both assertion and release.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;

    // Which qualified request decided the sampled READY value
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_ASYNC = 2'd2
    } rdy_src_e;

endpackage

// File: rtl/fall_sync.sv
module fall_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef logic [WIDTH-1:0] word_t;

    word_t stage_d [STAGES];
    word_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(negedge clk) begin
                stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ready_ctrl.sv
module ready_ctrl
    import bus_ready_pkg::*;
#(
    parameter int MIN_HOLD = 2
) (
    input  logic       clk,
    input  logic       rst_req_n,
    input  logic       pclk_i,
    input  logic [1:0] stat_n_i,
    input  logic       srdy_n_i,
    input  logic       ssel_n_i,
    input  logic [1:0] async_n_i,   // {ready, select}, already synchronized
    input  logic       reset_i,
    output logic       drive_o
);
    localparam int HOLD_W = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_HOLD - 1);

    typedef struct packed {
        logic              drive;
        logic [HOLD_W-1:0] hold;
        rdy_src_e          src;
    } ctrl_t;

    ctrl_t    st_d, st_q;
    logic     status_busy;
    logic     async_hit;
    logic     sync_hit;
    rdy_src_e pick;

    always_comb begin
        status_busy = ~(&stat_n_i);
        async_hit   = pclk_i && (async_n_i == 2'b00);
        sync_hit    = pclk_i && !status_busy && !srdy_n_i && !ssel_n_i;

        // the asynchronous source wins when both qualify
        if (async_hit)     pick = SRC_ASYNC;
        else if (sync_hit) pick = SRC_SYNC;
        else               pick = SRC_NONE;

        st_d = st_q;
        if (reset_i) begin
            st_d.drive = 1'b1;
            st_d.hold  = HOLD_LOAD;
            st_d.src   = SRC_NONE;
        end else if (st_q.hold != '0) begin
            st_d.drive = 1'b1;
            st_d.hold  = st_q.hold - 1'b1;
        end else if (status_busy) begin
            st_d.drive = 1'b0;
            st_d.src   = SRC_NONE;
        end else if (pclk_i) begin
            st_d.drive = (pick != SRC_NONE);
            st_d.src   = pick;
            if ((pick != SRC_NONE) && !st_q.drive) begin
                st_d.hold = HOLD_LOAD;
            end
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign drive_o = st_q.drive;

    // R7: a fresh assertion survives the following edge
    assert_hold_min_R7: assert property (@(negedge clk) disable iff (!rst_req_n || reset_i)
        $rose(st_q.drive) |=> st_q.drive);

    // R8: bus cycle start after the hold window releases the line
    assert_float_on_status_R8: assert property (@(negedge clk) disable iff (!rst_req_n || reset_i)
        (status_busy && st_q.hold == '0) |=> !st_q.drive);

    // R4: with the peripheral clock low and nothing pending, the drive holds
    assert_pclk_gate_R4: assert property (@(negedge clk) disable iff (!rst_req_n || reset_i)
        (!pclk_i && !status_busy && st_q.hold == '0) |=> $stable(st_q.drive));
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen #(
    parameter int MIN_HOLD     = 2,
    parameter int ASYNC_STAGES = 2,
    parameter int RESET_STAGES = 2
) (
    input  logic sys_clk,
    input  logic periph_clk,
    input  logic stat1_n,
    input  logic stat0_n,
    input  logic sync_rdy_n,
    input  logic sync_sel_n,
    input  logic async_rdy_n,
    input  logic async_sel_n,
    input  logic rst_req_n,
    output logic ready_pull_o,
    output logic sys_reset_o
);
    logic [1:0] async_s;
    logic       reset_s;

    fall_sync #(.WIDTH(2), .STAGES(ASYNC_STAGES)) u_async_sync (
        .clk  (sys_clk),
        .din  ({async_rdy_n, async_sel_n}),
        .dout (async_s)
    );

    fall_sync #(.WIDTH(1), .STAGES(RESET_STAGES)) u_reset_sync (
        .clk  (sys_clk),
        .din  (~rst_req_n),
        .dout (reset_s)
    );

    ready_ctrl #(.MIN_HOLD(MIN_HOLD)) u_ctrl (
        .clk       (sys_clk),
        .rst_req_n (rst_req_n),
        .pclk_i    (periph_clk),
        .stat_n_i  ({stat1_n, stat0_n}),
        .srdy_n_i  (sync_rdy_n),
        .ssel_n_i  (sync_sel_n),
        .async_n_i (async_s),
        .reset_i   (reset_s),
        .drive_o   (ready_pull_o)
    );

    assign sys_reset_o = reset_s;

    // R2: a high reset output forces READY on the next edge
    assert_reset_forces_ready_R2: assert property (@(negedge sys_clk) disable iff (!rst_req_n)
        sys_reset_o |=> ready_pull_o);

    // R1: reset can only fall once the request has been high long enough
    assert_reset_release_R1: assert property (@(negedge sys_clk) disable iff (!rst_req_n)
        $fell(sys_reset_o) |-> $past(rst_req_n, 2));
endmodule

// File: tb/bus_ready_gen_test.sv
module bus_ready_gen_test;
    logic sys_clk = 1'b0;
    logic periph_clk, stat1_n, stat0_n, sync_rdy_n, sync_sel_n;
    logic async_rdy_n, async_sel_n, rst_req_n;
    logic ready_pull_o, sys_reset_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 sys_clk = ~sys_clk;   // 50 MHz

    bus_ready_gen uut (
        .sys_clk      (sys_clk),
        .periph_clk   (periph_clk),
        .stat1_n      (stat1_n),
        .stat0_n      (stat0_n),
        .sync_rdy_n   (sync_rdy_n),
        .sync_sel_n   (sync_sel_n),
        .async_rdy_n  (async_rdy_n),
        .async_sel_n  (async_sel_n),
        .rst_req_n    (rst_req_n),
        .ready_pull_o (ready_pull_o),
        .sys_reset_o  (sys_reset_o)
    );

    // {rst_req_n, periph_clk, stat1_n, stat0_n, sync_rdy_n, sync_sel_n,
    //  async_rdy_n, async_sel_n, exp_drive, exp_reset, care_drive, care_reset}
    localparam int NV = 38;
    localparam logic [11:0] VEC [NV] = '{
        12'b0011_1111_0000,  // 0  reset request, state unknown
        12'b0011_1111_0101,  // 1  R1 reset rises
        12'b0011_1111_1111,  // 2  R2 forced ready
        12'b1011_1111_1111,  // 3  R2
        12'b1011_1111_1011,  // 4  R1 reset falls, R2 one later
        12'b1011_1111_1011,  // 5  hold after reset
        12'b1101_1111_0011,  // 6  R8 status low releases
        12'b1011_0011_0011,  // 7  R4 pclk low ignores sync pair
        12'b1111_0011_1011,  // 8  R3 sync ready
        12'b1011_1111_1011,  // 9  R7 hold
        12'b1111_1111_0011,  // 10 R9 inactive sample releases
        12'b1110_0011_0011,  // 11 R4 status low ignores sync pair
        12'b1111_0111_0011,  // 12 R3 select high only
        12'b1111_1100_0011,  // 13 R5 stage 1
        12'b1011_1100_0011,  // 14 R5 stage 2, pclk low
        12'b1111_1100_1011,  // 15 R5 async ready
        12'b1011_1111_1011,  // 16 R7 hold
        12'b1111_1111_1011,  // 17 R5 release delayed
        12'b1111_1111_0011,  // 18 R5 release seen
        12'b1111_0011_1011,  // 19 R9
        12'b1011_0011_1011,  // 20 R9
        12'b1111_0011_1011,  // 21 R9 stays while active
        12'b1101_0011_0011,  // 22 R8
        12'b1111_1100_0011,  // 23 R6
        12'b1011_0000_0011,  // 24 R6 pclk low
        12'b1111_0000_1011,  // 25 R6 both sources
        12'b1011_1111_1011,  // 26 R6 hold
        12'b1110_1111_0011,  // 27 R8
        12'b1111_0011_1011,  // 28 R7
        12'b1101_1111_1011,  // 29 R7 hold beats status
        12'b1101_1111_0011,  // 30 R8
        12'b0111_1111_0011,  // 31 R1 request mid-run
        12'b0111_1111_0111,  // 32 R1 / R2 one later
        12'b0101_1111_1111,  // 33 R2 despite status low
        12'b1101_1111_1111,  // 34 R2
        12'b1111_1111_1011,  // 35 R1 falls
        12'b1111_1111_1011,  // 36 R2 hold after release
        12'b1111_1111_0011   // 37 R9
    };

    function automatic string req_of(int row);
        if (row <= 5 || row >= 31) return "R2";
        if (row == 6 || row == 22 || row == 27 || row == 30) return "R8";
        if (row == 7 || row == 11) return "R4";
        if (row == 8 || row == 12) return "R3";
        if (row == 9 || (row >= 28 && row <= 29)) return "R7";
        if (row >= 13 && row <= 18) return "R5";
        if (row >= 23 && row <= 26) return "R6";
        return "R9";
    endfunction

    task automatic apply(input logic [7:0] in);
        {rst_req_n, periph_clk, stat1_n, stat0_n,
         sync_rdy_n, sync_sel_n, async_rdy_n, async_sel_n} = in;
        @(posedge sys_clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        @(posedge sys_clk);
        #1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][11:4]);
            if (VEC[i][0]) check("R1", $sformatf("row %0d reset", i), sys_reset_o, VEC[i][2]);
            if (VEC[i][1]) check(req_of(i), $sformatf("row %0d drive", i), ready_pull_o, VEC[i][3]);
        end

        // R6: asynchronous select alone, ready high, never asserts
        for (int k = 0; k < 4; k++) begin
            apply(8'b1111_1110);
            check("R6", "select-only async", ready_pull_o, 1'b0);
        end
        // R5: async pair low for a single edge still reaches READY two edges later
        apply(8'b1111_1100);
        check("R5", "pulse edge0", ready_pull_o, 1'b0);
        apply(8'b1011_1111);
        check("R5", "pulse edge1", ready_pull_o, 1'b0);
        apply(8'b1111_1111);
        check("R5", "pulse edge2", ready_pull_o, 1'b1);
        apply(8'b1111_1111);
        check("R7", "pulse hold", ready_pull_o, 1'b1);
        apply(8'b1111_1111);
        check("R9", "pulse gone", ready_pull_o, 1'b0);
        // R1: a one-edge request still produces a one-edge reset pulse
        apply(8'b0111_1111);
        check("R1", "short req edge0", sys_reset_o, 1'b0);
        apply(8'b1111_1111);
        check("R1", "short req edge1", sys_reset_o, 1'b1);
        apply(8'b1111_1111);
        check("R1", "short req edge2", sys_reset_o, 1'b0);
        check("R2", "short req forced", ready_pull_o, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule